// File: doc/BRIEF.md
# Memory-Fed Multichannel LED PWM Engine

This block drives a bank of one-bit pulse-width outputs for LED brightness control, typically three channels per RGB LED. Every channel's intensity sits in one dual-port memory. A host stores intensities through a write port (address, data, enable) whenever it likes. The engine reads that memory only through the second port. Once per PWM period it sweeps the channel addresses in ascending order and copies each intensity into a per-channel holding register. At the period boundary all holding registers move into per-channel down-counters in the same cycle, so every output starts its pulse on the same clock.

Each clock cycle is one PWM tick. A period lasts `PERIOD` ticks. With the default of 16-bit intensities and 65,536 ticks per period, a 1 ms refresh needs a 65.536 MHz clock. An output stays high while its counter is nonzero. Intensity 0 gives a dark channel, and the largest code lights the channel for every tick except the last one. Writes to addresses at or above the channel count are discarded.

Top module: `pwm_ram_engine`

## Requirements
- R1: A synchronous active-high `rst` drives every output low from the clock edge that samples it. The whole first period after reset is low. Stored intensities are not cleared by reset, and they drive the second period.
- R2: A channel holding intensity D, with 0 < D < PERIOD, is high for exactly the first D ticks of a period and low for the rest. Tick 0 of a period is the cycle after the boundary edge. The intensity is written by holding `wr_en` high with `wr_addr` set to the channel index and `wr_data` set to D, across one rising edge.
- R3: All channels with a nonzero intensity rise in the same cycle, tick 0 of a period. No output rises in any other cycle.
- R4: A channel holding intensity 0 stays low for the entire period.
- R5: With PERIOD equal to 2^DW, a channel holding 2^DW-1 is high for ticks 0 to PERIOD-2 and low only on tick PERIOD-1.
- R6: Channel c's intensity is sampled at the clock edge that ends tick PERIOD-NCH-2+c of the preceding period. A write committed at an earlier edge applies in the next period. A write committed at that same edge or later applies one period later.
- R7: A write to one channel leaves the waveforms of all other channels unchanged.
- R8: Without new writes, every channel repeats the same waveform in each period of PERIOD ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one PWM tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | AW = max(1, clog2(NCH)) | Channel index for the write |
| wr_data | input | DW | Intensity value to store |
| pwm_o | output | NCH | One PWM output per channel, bit i for channel i |

## Verification
The case hardest to reach from the ports is a host write that lands exactly on the edge where the sweep reads that channel. The read returns the old word, so the new intensity appears one period later than a write made one cycle earlier would. The stimulus keeps its own tick counter from the release of reset. It places consecutive writes at ticks just before, at, and just after each channel's read slot. A predictor snapshots a model memory at those same slots and queues the expected output vector for every tick of the following period.

// File: rtl/pwm_ram_pkg.sv
package pwm_ram_pkg;

  // Tick at which the sweep issues the read for channel 0. The sweep occupies
  // NCH ticks, the returned word lands one tick later, and one spare tick
  // separates the last capture from the boundary transfer.
  function automatic int scan_first(input int period, input int nch);
    return period - nch - 2;
  endfunction

  // Address width for an NCH-deep channel table (never zero).
  function automatic int addr_bits(input int nch);
    return (nch > 1) ? $clog2(nch) : 1;
  endfunction

  // Width of the tick counter for a period of the given length.
  function automatic int tick_bits(input int period);
    return (period > 1) ? $clog2(period) : 1;
  endfunction

endpackage

// File: rtl/pwm_duty_ram.sv
module pwm_duty_ram #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem_q [0:WORDS-1];

  // Host port: write only.
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  // Engine port: registered read. It returns the word held before any write
  // at the same edge.
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem_q[rd_addr];
  end

endmodule

// File: rtl/pwm_scan_seq.sv
module pwm_scan_seq
  import pwm_ram_pkg::*;
#(
  parameter int NCH    = 63,
  parameter int PERIOD = 65536,
  parameter int AW     = 6,
  parameter int PW     = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          cap_en,
  output logic [AW-1:0] cap_idx,
  output logic          boundary
);
  localparam int SCAN_LO = scan_first(PERIOD, NCH);
  localparam int SCAN_HI = SCAN_LO + NCH;

  logic [PW-1:0] tick_q;
  logic          in_scan;
  logic          last_tick;

  assign last_tick = (tick_q == PW'(PERIOD - 1));
  assign in_scan   = (tick_q >= PW'(SCAN_LO)) && (tick_q < PW'(SCAN_HI));
  assign rd_en     = in_scan;
  assign rd_addr   = AW'(tick_q - PW'(SCAN_LO));
  assign boundary  = last_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
    end else if (last_tick) begin
      tick_q <= '0;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  // The read data shows up one cycle after the address, so the capture
  // strobe and the channel index are delayed to match.
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_en  <= 1'b0;
      cap_idx <= '0;
    end else begin
      cap_en  <= in_scan;
      cap_idx <= rd_addr;
    end
  end

  a_r6_scan_in_range: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (int'(rd_addr) < NCH));

  a_r6_scan_ascending: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(rd_addr) < NCH - 1) |=> (rd_en && rd_addr == $past(rd_addr) + 1'b1));

  a_r6_capture_before_boundary: assert property (@(posedge clk) disable iff (rst)
    boundary |-> !cap_en);

  a_r8_single_boundary: assert property (@(posedge clk) disable iff (rst)
    boundary |=> !boundary);

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [DW-1:0] cap_data,
  input  logic          load,
  output logic          pwm_o
);
  logic [DW-1:0] hold_q;
  logic [DW-1:0] cnt_q;

  function automatic logic level_of(input logic [DW-1:0] cnt);
    return cnt != '0;
  endfunction

  assign pwm_o = level_of(cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (cap_en) begin
      hold_q <= cap_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= hold_q;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r2_load_from_hold: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(hold_q)));

  a_r2_count_never_rises: assert property (@(posedge clk) disable iff (rst)
    !load |=> (cnt_q <= $past(cnt_q)));

  a_r4_low_stays_low: assert property (@(posedge clk) disable iff (rst)
    (!pwm_o && !load) |=> !pwm_o);

  a_r6_hold_only_on_capture: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> $stable(hold_q));

endmodule

// File: rtl/pwm_ram_engine.sv
module pwm_ram_engine
  import pwm_ram_pkg::*;
#(
  parameter int NCH    = 63,
  parameter int DW     = 16,
  parameter int PERIOD = 65536,
  parameter int AW     = addr_bits(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_o
);
  localparam int PW = tick_bits(PERIOD);

  logic          wr_ok;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          cap_en;
  logic [AW-1:0] cap_idx;
  logic          boundary;

  // Addresses past the last channel have no output behind them.
  assign wr_ok = wr_en && (int'(wr_addr) < NCH);

  pwm_duty_ram #(.DW(DW), .AW(AW)) ram_i (
    .clk     (clk),
    .wr_en   (wr_ok),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  pwm_scan_seq #(.NCH(NCH), .PERIOD(PERIOD), .AW(AW), .PW(PW)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .cap_en   (cap_en),
    .cap_idx  (cap_idx),
    .boundary (boundary)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
    logic sel;
    assign sel = cap_en && (cap_idx == AW'(gi));
    pwm_chan #(.DW(DW)) chan_i (
      .clk      (clk),
      .rst      (rst),
      .cap_en   (sel),
      .cap_data (rd_data),
      .load     (boundary),
      .pwm_o    (pwm_o[gi])
    );
  end

  a_r3_rise_only_at_boundary: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> ((pwm_o & ~$past(pwm_o)) == '0));

  a_r1_low_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pwm_o == '0));

  a_r7_capture_one_channel: assert property (@(posedge clk) disable iff (rst)
    cap_en |-> (int'(cap_idx) < NCH));

endmodule

// File: tb/pwm_ram_engine_tb_top.sv
`timescale 1ns/1ps
module pwm_ram_engine_tb_top;
  localparam int NCH    = 4;
  localparam int DW     = 6;
  localparam int PERIOD = 64;
  localparam int AW     = 2;
  localparam int S      = PERIOD - NCH - 2;

  typedef struct {
    logic [NCH-1:0] v;
    string          tag;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [DW-1:0]  wr_data = '0;
  logic [NCH-1:0] pwm_o;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  bit    mon_on = 1'b0;
  int    tph = 0;
  int    tper = 0;
  string next_tag = "R2 R3 R4 R5";
  int    mmod [NCH];
  int    snap [NCH];
  exp_t  q [$];

  always #2 clk = ~clk;

  pwm_ram_engine #(.NCH(NCH), .DW(DW), .PERIOD(PERIOD), .AW(AW)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_o   (pwm_o)
  );

  task automatic push_period(input string tag);
    for (int p = 0; p < PERIOD; p++) begin
      exp_t e;
      for (int c = 0; c < NCH; c++) e.v[c] = (p < snap[c]);
      e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic push_dark(input string tag);
    for (int p = 0; p < PERIOD; p++) begin
      exp_t e;
      e.v = '0;
      e.tag = tag;
      q.push_back(e);
    end
  endtask

  // Monitor and predictor: compare the output once per tick, then model the
  // sweep snapshots and host writes that take effect at the coming edge.
  always @(negedge clk) begin
    if (mon_on) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL queue empty at period %0d tick %0d: actual %b expected none", tper, tph, pwm_o);
      end else begin
        e = q.pop_front();
        if (pwm_o !== e.v) begin
          errors++;
          $display("FAIL %s period %0d tick %0d: actual %b expected %b", e.tag, tper, tph, pwm_o, e.v);
        end
      end
      for (int c = 0; c < NCH; c++) if (tph == S + c) snap[c] = mmod[c];
      if (wr_en && int'(wr_addr) < NCH) mmod[wr_addr] = int'(wr_data);
      if (tph == PERIOD - 1) push_period(next_tag);
      tph = (tph + 1) % PERIOD;
      if (tph == 0) tper++;
    end
  end

  task automatic hwrite(input int a, input int d);
    wr_en = 1'b1;
    wr_addr = AW'(a);
    wr_data = DW'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic go(input int per, input int ph);
    while (!(tper == per && tph == ph)) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin mmod[c] = 0; snap[c] = 0; end
    push_dark("R1");
    repeat (3) @(posedge clk);
    #1 rst = 1'b0; mon_on = 1'b1; tph = 0; tper = 0;

    // R2 R4 R5: mid value, zero, full scale and minimum, written before the sweep.
    go(0, 2);
    hwrite(0, 10); hwrite(1, 0); hwrite(2, 63); hwrite(3, 1);

    // R7 R8: change two channels; the other two must repeat unchanged.
    go(1, 5);
    next_tag = "R7 R8";
    hwrite(0, 33); hwrite(3, 20);

    // R6: writes just before, right after, on, and after each read slot.
    go(2, 5);
    next_tag = "R6";
    go(2, S + 1);
    hwrite(2, 5);   // commits before channel 2 is read: next period
    hwrite(1, 7);   // channel 1 already read: one period later
    hwrite(3, 44);  // same edge as channel 3 read: old value wins
    hwrite(0, 2);   // after channel 0 read: one period later
    go(3, 5);
    next_tag = "R6 R8";

    // R1: reset mid-period, outputs drop, dark period, stored values return.
    go(4, 10);
    mon_on = 1'b0;
    rst = 1'b1;
    @(posedge clk); #1;
    checks++;
    if (pwm_o !== '0) begin
      errors++;
      $display("FAIL R1 after reset edge: actual %b expected %b", pwm_o, {NCH{1'b0}});
    end
    @(posedge clk); #1;
    q.delete();
    for (int c = 0; c < NCH; c++) snap[c] = 0;
    push_dark("R1");
    next_tag = "R1";
    rst = 1'b0; tph = 0; tper = 0; mon_on = 1'b1;
    go(1, PERIOD - 1);
    @(negedge clk); #1;
    finish_run();
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual running expected finished");
      finish_run();
    end
  end

endmodule